// File: doc/BRIEF.md
# Circular Payload Transmit Reader

This block streams payload bytes out of a byte-wide packet RAM to a serializer. A host sets aside a window of the RAM, from a base address up to base plus a size, and the block reads it as a ring. Each byte is offered on a valid/ready handshake. When the last byte of the window has gone out, the read pointer returns to the base address and streaming goes on. Two interrupt sources tell the host when it may refill a part of the window. The almost-full source fires once the byte at a host-chosen mark offset has gone out. The full source fires once the byte at the last window address has gone out. The total frame length is a 16-bit byte count. It does not depend on the window size, so one frame may go round the window many times.

The host enables the block by setting bit 4 of a mode register. Before that, the host writes the frame length into RAM: the low byte at address 0x14 and the high byte at 0x15. The block reads these two bytes first, then streams until the count is reached or the host pulses a stop command. It then shows end-of-frame until the enable bit is cleared.

States: IDLE (waits for enable), LEN_LO (low length byte returns, high byte requested), LEN_HI (high length byte returns, first payload read issued or zero length detected), LOAD (RAM byte captured into the output register), SEND (byte offered until accepted), DONE (end-of-frame shown). Transitions: IDLE→LEN_LO on enable; LEN_LO→LEN_HI always; LEN_HI→DONE on zero length, otherwise →LOAD; LOAD→SEND always; SEND→LOAD on a handshake that is not the last; SEND→DONE on the last handshake; any state except IDLE→DONE on stop; any state→IDLE when enable is low.

Top module: `roll_tx_ctrl`

## Requirements
- R1: While bit 4 of `mode_cfg` is 0, the block issues no RAM read, never raises `tx_valid`, and keeps `tx_eof` low, whatever the other bits hold.
- R2: After enable, the first two RAM reads are at address 0x14 (length bits 7:0) and then at 0x15 (length bits 15:8).
- R3: Payload bytes are offered in address order starting at `win_base`. Each byte equals the RAM content of its address.
- R4: After the byte at `win_base + win_size` (8-bit sum) is accepted, the next byte comes from `win_base`.
- R5: Source bit 5 (almost-full) becomes 1 once the byte at `win_base + win_mark` is accepted, and not before.
- R6: Source bit 6 (full) becomes 1 once the byte at `win_base + win_size` is accepted, and not before.
- R7: Source bits stay set until the host pulses a 1 on the matching bit of `irq_clr`. Other bits are not affected by that pulse.
- R8: `irq` is 1 exactly when some source bit is 1 and its bit in `irq_mask` is 1.
- R9: Exactly the programmed length of bytes is accepted. `tx_eof` then rises, and `tx_valid` stays low after it.
- R10: A one-cycle `stop_cmd` during a frame moves the block to end-of-frame on the next clock, whatever the remaining count.
- R11: A length of zero yields `tx_eof` with no byte offered.
- R12: While `tx_valid` is 1 and `tx_ready` is 0 (and no stop), the next cycle keeps `tx_valid` at 1 and `tx_data` unchanged.
- R13: `tx_eof` stays 1 until enable is cleared, then drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_cfg | input | 8 | Mode register; bit 4 enables transmit streaming |
| win_base | input | 8 | First RAM address of the ring window |
| win_size | input | 8 | Offset of the last window address from the base |
| win_mark | input | 8 | Offset of the byte that triggers almost-full |
| stop_cmd | input | 1 | Host stop pulse |
| irq_mask | input | 8 | Interrupt enable per source bit |
| irq_clr | input | 8 | Write-one-to-clear pulse per source bit |
| ram_rd | output | 1 | RAM read strobe |
| ram_addr | output | 8 | RAM read address |
| ram_rdata | input | 8 | RAM read data, one cycle after the strobe |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Byte on `tx_data` is valid |
| tx_ready | input | 1 | Serializer accepts the byte |
| tx_eof | output | 1 | End of frame reached |
| irq_src | output | 8 | Sticky interrupt sources (bit 6 full, bit 5 almost-full) |
| irq | output | 1 | Masked interrupt request |

## Verification
The stream is checked under three patterns of `tx_ready`: always high, alternating, and a pseudo-random pattern. Always-high shows the base read rate and the wrap seam. Alternating and random stalls show whether the byte is held across back-pressure and whether a byte gets lost or repeated. Frame lengths of 3, 4, 8 and 20 against an 8-byte window with a mark offset of 3 show apart the cases "mark not yet reached", "mark only", "full" and "several wraps". A zero length and a stop in the middle of a long frame cover the two ways a frame ends early.

// File: rtl/roll_tx_pkg.sv
package roll_tx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LEN_LO,
        S_LEN_HI,
        S_LOAD,
        S_SEND,
        S_DONE
    } tx_state_t;
endpackage

// File: rtl/roll_tx_ptr.sv
module roll_tx_ptr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] mark,
    input  logic          load,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt,
    output logic          at_last,
    output logic          at_mark
);
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] last_adr;
    logic [AW-1:0] mark_adr;

    assign last_adr = base + size;
    assign mark_adr = base + mark;
    assign at_last  = (ptr_q == last_adr);
    assign at_mark  = (ptr_q == mark_adr);
    assign ptr_nxt  = at_last ? base : ptr_q + AW'(1);
    assign ptr      = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= base;
        end else if (step) begin
            ptr_q <= ptr_nxt;
        end
    end
endmodule

// File: rtl/roll_tx_cnt.sv
module roll_tx_cnt #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [LW-1:0] total,
    output logic          is_last
);
    logic [LW-1:0] cnt_q;

    assign is_last = ((cnt_q + LW'(1)) == total);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end
endmodule

// File: rtl/roll_tx_irq.sv
module roll_tx_irq #(
    parameter int IW       = 8,
    parameter int FULL_BIT = 6,
    parameter int AF_BIT   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_full,
    input  logic          set_af,
    input  logic [IW-1:0] clr,
    input  logic [IW-1:0] mask,
    output logic [IW-1:0] src,
    output logic          irq
);
    logic [IW-1:0] src_q;
    logic [IW-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[FULL_BIT] = set_full;
        set_vec[AF_BIT]   = set_af;
    end

    for (genvar b = 0; b < IW; b++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q[b] <= 1'b0;
            end else if (set_vec[b]) begin
                src_q[b] <= 1'b1;
            end else if (clr[b]) begin
                src_q[b] <= 1'b0;
            end
        end
    end

    assign src = src_q;
    assign irq = |(src_q & mask);
endmodule

// File: rtl/roll_tx_ctrl.sv
module roll_tx_ctrl
    import roll_tx_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 8,
    parameter int            IW          = 8,
    parameter int            EN_BIT      = 4,
    parameter int            FULL_BIT    = 6,
    parameter int            AF_BIT      = 5,
    parameter logic [AW-1:0] LEN_LO_ADDR = 'h14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    mode_cfg,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_size,
    input  logic [AW-1:0] win_mark,
    input  logic          stop_cmd,
    input  logic [IW-1:0] irq_mask,
    input  logic [IW-1:0] irq_clr,
    output logic          ram_rd,
    output logic [AW-1:0] ram_addr,
    input  logic [DW-1:0] ram_rdata,
    output logic [DW-1:0] tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          tx_eof,
    output logic [IW-1:0] irq_src,
    output logic          irq
);
    localparam int            LW          = 2 * DW;
    localparam logic [AW-1:0] LEN_HI_ADDR = LEN_LO_ADDR + AW'(1);

    tx_state_t     state, nxt;
    logic          en;
    logic [DW-1:0] len_lo_q;
    logic [LW-1:0] total_q;
    logic [DW-1:0] dat_q;

    logic          ptr_load, ptr_step;
    logic [AW-1:0] ptr, ptr_nxt;
    logic          at_last, at_mark;
    logic          cnt_clr, cnt_inc, cnt_last;
    logic          lo_we, tot_we, dat_we;
    logic          hit_af, hit_full;

    assign en = mode_cfg[EN_BIT];

    roll_tx_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (win_base),
        .size    (win_size),
        .mark    (win_mark),
        .load    (ptr_load),
        .step    (ptr_step),
        .ptr     (ptr),
        .ptr_nxt (ptr_nxt),
        .at_last (at_last),
        .at_mark (at_mark)
    );

    roll_tx_cnt #(.LW(LW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .total   (total_q),
        .is_last (cnt_last)
    );

    roll_tx_irq #(.IW(IW), .FULL_BIT(FULL_BIT), .AF_BIT(AF_BIT)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_full (hit_full),
        .set_af   (hit_af),
        .clr      (irq_clr),
        .mask     (irq_mask),
        .src      (irq_src),
        .irq      (irq)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_lo_q <= '0;
            total_q  <= '0;
            dat_q    <= '0;
        end else begin
            if (lo_we)  len_lo_q <= ram_rdata;
            if (tot_we) total_q  <= {ram_rdata, len_lo_q};
            if (dat_we) dat_q    <= ram_rdata;
        end
    end

    // next state and controls
    always_comb begin
        nxt      = state;
        ram_rd   = 1'b0;
        ram_addr = ptr;
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        lo_we    = 1'b0;
        tot_we   = 1'b0;
        dat_we   = 1'b0;
        hit_af   = 1'b0;
        hit_full = 1'b0;
        if (!en) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    ram_rd   = 1'b1;
                    ram_addr = LEN_LO_ADDR;
                    ptr_load = 1'b1;
                    cnt_clr  = 1'b1;
                    nxt      = S_LEN_LO;
                end
                S_LEN_LO: begin
                    lo_we    = 1'b1;
                    ram_rd   = 1'b1;
                    ram_addr = LEN_HI_ADDR;
                    nxt      = S_LEN_HI;
                end
                S_LEN_HI: begin
                    tot_we = 1'b1;
                    if ({ram_rdata, len_lo_q} == '0) begin
                        nxt = S_DONE;
                    end else begin
                        ram_rd   = 1'b1;
                        ram_addr = ptr;
                        nxt      = S_LOAD;
                    end
                end
                S_LOAD: begin
                    dat_we = 1'b1;
                    nxt    = S_SEND;
                end
                S_SEND: begin
                    if (tx_ready) begin
                        cnt_inc  = 1'b1;
                        hit_af   = at_mark;
                        hit_full = at_last;
                        if (cnt_last) begin
                            nxt = S_DONE;
                        end else begin
                            ptr_step = 1'b1;
                            ram_rd   = 1'b1;
                            ram_addr = ptr_nxt;
                            nxt      = S_LOAD;
                        end
                    end
                end
                S_DONE: begin
                    nxt = S_DONE;
                end
                default: nxt = S_IDLE;
            endcase
            if (stop_cmd && state != S_IDLE) begin
                nxt = S_DONE;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = (state == S_SEND);
        tx_eof   = (state == S_DONE);
        tx_data  = dat_q;
    end
endmodule

// File: rtl/roll_tx_chk.sv
module roll_tx_chk #(
    parameter int IW       = 8,
    parameter int DW       = 8,
    parameter int EN_BIT   = 4,
    parameter int FULL_BIT = 6,
    parameter int AF_BIT   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    mode_cfg,
    input logic          stop_cmd,
    input logic [IW-1:0] irq_mask,
    input logic [IW-1:0] irq_clr,
    input logic [DW-1:0] tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_eof,
    input logic [IW-1:0] irq_src,
    input logic          irq
);
    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cfg[EN_BIT] |=> !tx_valid && !tx_eof);

    // R12
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !stop_cmd && mode_cfg[EN_BIT])
        |=> tx_valid && $stable(tx_data));

    // R7
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src[FULL_BIT] && !irq_clr[FULL_BIT]) |=> irq_src[FULL_BIT]);

    // R7
    af_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_src[AF_BIT] && !irq_clr[AF_BIT]) |=> irq_src[AF_BIT]);

    // R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);

    // R9
    quiet_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_eof && mode_cfg[EN_BIT]) |=> !tx_valid && tx_eof);

    // R10
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && mode_cfg[EN_BIT] && (tx_valid || tx_eof)) |=> tx_eof || !mode_cfg[EN_BIT]);
endmodule

bind roll_tx_ctrl roll_tx_chk #(
    .IW(IW), .DW(DW), .EN_BIT(EN_BIT), .FULL_BIT(FULL_BIT), .AF_BIT(AF_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_cfg (mode_cfg),
    .stop_cmd (stop_cmd),
    .irq_mask (irq_mask),
    .irq_clr  (irq_clr),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_eof   (tx_eof),
    .irq_src  (irq_src),
    .irq      (irq)
);

// File: tb/sim_roll_tx_ctrl.sv
`timescale 1ns/1ps
module sim_roll_tx_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_cfg = 8'h00;
    logic [7:0] win_base = 8'h20, win_size = 8'h07, win_mark = 8'h03;
    logic       stop_cmd = 1'b0;
    logic [7:0] irq_mask = 8'h00, irq_clr = 8'h00;
    logic       ram_rd;
    logic [7:0] ram_addr;
    logic [7:0] ram_rdata = 8'h00;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       tx_eof;
    logic [7:0] irq_src;
    logic       irq;

    logic [7:0] mem [256];
    logic [7:0] exp_q [$];
    int total = 0, bad = 0;
    int hs_n = 0, rd_n = 0;
    logic [7:0] rd_log [4];
    int rmode = 0;
    logic [7:0] lfsr = 8'h5B;
    logic       prev_hold = 1'b0;
    logic [7:0] prev_data = 8'h00;

    always #10 clk = ~clk;

    roll_tx_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg),
        .win_base(win_base), .win_size(win_size), .win_mark(win_mark),
        .stop_cmd(stop_cmd), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_eof(tx_eof), .irq_src(irq_src), .irq(irq)
    );

    // RAM model: one cycle read latency
    always @(posedge clk) if (ram_rd) ram_rdata <= mem[ram_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ready driver
    initial forever begin
        @(posedge clk); #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rmode)
            0: tx_ready = 1'b1;
            1: tx_ready = ~tx_ready;
            default: tx_ready = lfsr[0];
        endcase
    end

    // monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (ram_rd && rd_n < 4) rd_log[rd_n] = ram_addr;
        if (ram_rd) rd_n++;
        if (prev_hold)
            check(tx_valid && tx_data == prev_data, "R12 held byte", {tx_valid, tx_data}, {1'b1, prev_data});
        prev_hold = tx_valid && !tx_ready && !stop_cmd;
        prev_data = tx_data;
        if (tx_valid && tx_ready) begin
            hs_n++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 extra byte", tx_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(tx_data == e, "R3/R4 byte", tx_data, e);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_clr(input logic [7:0] v);
        irq_clr = v; cyc(1); irq_clr = 8'h00; cyc(1);
    endtask

    // driver: prepares RAM and pushes expected bytes
    task automatic start_run(input logic [7:0] b, input logic [7:0] s, input logic [7:0] m,
                             input int len, input int rm);
        mode_cfg = 8'h00; cyc(2);
        win_base = b; win_size = s; win_mark = m; rmode = rm;
        mem[8'h14] = len[7:0]; mem[8'h15] = len[15:8];
        for (int i = 0; i <= int'(s); i++) mem[8'(int'(b) + i)] = 8'(i * 29 + 7 + int'(b));
        exp_q.delete();
        for (int k = 0; k < len; k++) exp_q.push_back(mem[8'(int'(b) + (k % (int'(s) + 1)))]);
        pulse_clr(8'hFF);
        hs_n = 0; rd_n = 0;
        mode_cfg = 8'h10;
    endtask

    task automatic wait_eof(input string tag);
        int t = 0;
        while (!tx_eof && t < 6000) begin @(negedge clk); t++; end
        check(tx_eof, tag, tx_eof, 1);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        cyc(3); rst_n = 1'b1; @(negedge clk);
        // reset state
        check(!tx_valid && !tx_eof && irq_src == 0 && !irq && !ram_rd, "R1 reset", {tx_valid, tx_eof, irq}, 0);

        // R1: other mode bits set, enable clear
        rd_n = 0; hs_n = 0; mode_cfg = 8'hEF; cyc(20); @(negedge clk);
        check(rd_n == 0 && hs_n == 0 && !tx_eof, "R1 disabled", rd_n, 0);

        // R5 boundary: length 3 stops before the mark
        start_run(8'h20, 8'h07, 8'h03, 3, 0); wait_eof("R9 eof len3");
        check(hs_n == 3, "R9 count len3", hs_n, 3);
        check(rd_log[0] == 8'h14 && rd_log[1] == 8'h15, "R2 length reads", {rd_log[0], rd_log[1]}, 16'h1415);
        check(irq_src[5] == 1'b0, "R5 not before mark", irq_src, 0);

        // R5: length 4 reaches the mark only
        start_run(8'h20, 8'h07, 8'h03, 4, 1); wait_eof("R9 eof len4");
        check(irq_src[5] == 1'b1 && irq_src[6] == 1'b0, "R5/R6 mark only", irq_src, 8'h20);
        check(!irq, "R8 masked off", irq, 0);

        // R6: length 8 reaches the last window byte
        start_run(8'h20, 8'h07, 8'h03, 8, 2); wait_eof("R9 eof len8");
        check(irq_src[6] == 1'b1, "R6 full", irq_src, 8'h60);

        // R4: several wraps, alternating ready
        start_run(8'h20, 8'h07, 8'h03, 20, 1); wait_eof("R9 eof len20");
        check(hs_n == 20 && exp_q.size() == 0, "R4 wrap count", hs_n, 20);
        cyc(5); @(negedge clk);
        check(hs_n == 20 && tx_eof, "R9 quiet after eof", hs_n, 20);
        irq_mask = 8'h40; cyc(1); @(negedge clk);
        check(irq, "R8 full unmasked", irq, 1);
        pulse_clr(8'h20); @(negedge clk);
        check(irq_src[5] == 1'b0 && irq_src[6] == 1'b1, "R7 clear af only", irq_src, 8'h40);
        pulse_clr(8'h40); @(negedge clk);
        check(irq_src == 0 && !irq, "R7 clear full", irq_src, 0);
        irq_mask = 8'h00;

        // R13: eof drops after enable cleared
        mode_cfg = 8'h00; cyc(1); @(negedge clk);
        check(!tx_eof, "R13 eof release", tx_eof, 0);

        // R11: zero length
        start_run(8'h30, 8'h0F, 8'h07, 0, 0); wait_eof("R11 eof");
        cyc(3); @(negedge clk);
        check(hs_n == 0, "R11 no bytes", hs_n, 0);

        // R10: stop mid-frame, random ready
        start_run(8'h40, 8'h0F, 8'h07, 1000, 2);
        cyc(60);
        stop_cmd = 1'b1; cyc(1); stop_cmd = 1'b0; @(negedge clk);
        check(tx_eof, "R10 stop", tx_eof, 1);
        check(hs_n > 0 && hs_n < 1000, "R10 partial", hs_n, 1);
        exp_q.delete();
        cyc(4); @(negedge clk);
        check(!tx_valid && tx_eof, "R10 stays ended", tx_valid, 0);

        mode_cfg = 8'h00; cyc(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule